// File: doc/BRIEF.md
# Bus Request Grant Controller

This block lets an external master borrow the processor's memory bus. The master drops an asynchronous active-low request. The block brings that request into the clock domain. It waits for a safe point and then lends the bus. While the bus is lent, the block drives an active-low grant, turns off the processor's address, data, select and strobe drivers, and stalls the core.

A safe point is the end of the current external memory access, or the end of the current boot byte load. It is not the end of the whole instruction. This means an instruction that makes two external accesses can lose the bus between them. When go mode is on, the core keeps running from internal memory while the bus is lent. It stalls only when it needs the external bus. A hung flag tells the other master that the core has a stalled external access waiting.

The block gives the bus back when the master lifts its request. The memory sequencer, the boot loader and the core pipeline are outside this block. They reach it only as status inputs.

Top module: `bus_grant_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it rises with no request, the outputs are `bus_grant_n`=1, `drv_en`=1, `core_halt`=0 and `grant_hung`=0.
- R2: The request passes through a two-flop synchronizer. It counts as recognised in the cycle in which the second flop first reads it active. With no access or boot load pending, `bus_grant_n` goes low in the cycle after recognition, which is three rising edges after `bus_req_n` is first sampled low.
- R3: While `ext_busy`=1 and `ext_done`=0, no grant starts. In the cycle after a cycle with `ext_done`=1, the grant is asserted.
- R4: When a second external access is waiting (`next_ext`=1) after the first one completes, the bus is still granted. The waiting access stays stalled until the request is released.
- R5: With `go_mode`=0, `core_halt` rises in the same cycle as the grant and stays high for as long as the grant lasts.
- R6: With `go_mode`=1, `core_halt` stays low during the grant until `next_ext` is sampled high. It rises in the next cycle and then stays high until the grant ends.
- R7: When the request is removed, `bus_grant_n`, `core_halt`, `grant_hung` and `drv_en` all return to their idle values in the cycle in which the second synchronizer flop reads the request inactive. This is two rising edges after `bus_req_n` is sampled high.
- R8: While `chip_reset`=1, the grant is asserted in the same cycle the request is recognised (two edges after `bus_req_n` is sampled low). Any pending access is ignored.
- R9: While `boot_busy`=1 and `boot_done`=0, no grant starts. In the cycle after a cycle with `boot_done`=1, the grant is asserted.
- R10: `grant_hung` is high exactly in the cycles after an edge at which the grant is held or starts while `next_ext`=1.
- R11: `drv_en` is always the logical complement of the active grant, so `drv_en` equals `bus_grant_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous active-low reset of this block |
| bus_req_n | input | 1 | Asynchronous active-low request from the other master |
| chip_reset | input | 1 | Processor reset is active |
| ext_busy | input | 1 | An external memory access is in progress |
| ext_done | input | 1 | The current external access completes in this cycle |
| boot_busy | input | 1 | A boot byte load is in progress, including its wait states |
| boot_done | input | 1 | The current boot byte load completes in this cycle |
| next_ext | input | 1 | The core's next access needs the external bus |
| go_mode | input | 1 | Keep the core running on internal memory while the bus is lent |
| bus_grant_n | output | 1 | Active-low bus grant |
| drv_en | output | 1 | 1 = drive the address, data, select and strobe pins; 0 = tristate them |
| core_halt | output | 1 | Stall the core |
| grant_hung | output | 1 | The core is stalled on an external access because the bus is lent |

## Verification
Each done input is assumed to be a qualifier for the cycle it appears in. Its companion busy input decides whether a grant is blocked, so a done pulse with no busy signal changes nothing. The properties that block a grant sample `chip_reset` in the same cycle as the busy flag. They therefore depend on every input being held steady across each rising edge. The bench keeps to this by changing inputs only on the falling edge. Go mode may change at any time in the random phase, because the halt properties are written one cycle ahead and use the go-mode value that the design itself sampled.

// File: rtl/bgc_pkg.sv
// Package: shared types and constants for the bus grant controller.
// Assumes: all grant-side flags are active high inside the block.
package bgc_pkg;

    // Number of access fences (external memory access, boot byte load).
    localparam int unsigned BGC_NUM_FENCE = 2;
    localparam int unsigned BGC_FENCE_EXT  = 0;
    localparam int unsigned BGC_FENCE_BOOT = 1;

    // Registered outputs of the grant core.
    typedef struct packed {
        logic grant;
        logic halt;
        logic hung;
        logic drv_en;
    } bgc_out_t;

    localparam bgc_out_t BGC_OUT_IDLE = '{grant: 1'b0, halt: 1'b0, hung: 1'b0, drv_en: 1'b1};

endpackage

// File: rtl/bgc_req_sync.sv
// Module: bgc_req_sync
// Brings the asynchronous active-low request into the clock domain through
// a chain of STAGES flops. It outputs the last stage (the recognised request)
// and the stage before it (the request that will be recognised one cycle later).
// Assumes: STAGES >= 2; reset leaves the request inactive.
module bgc_req_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_async,
    output logic req_sync,
    output logic req_early
);
    localparam int unsigned LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // First stage: capture the inverted raw request.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= ~req_n_async;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Later stages: shift the request one flop further.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[gi] <= 1'b0;
                else        chain_q[gi] <= chain_q[gi-1];
            end
        end
    endgenerate

    assign req_sync  = chain_q[LAST];
    assign req_early = chain_q[LAST-1];

endmodule

// File: rtl/bgc_fence.sv
// Module: bgc_fence
// Reports whether one kind of bus activity allows a grant to start: it does when
// nothing is in progress, or when the current transfer completes this cycle.
// Assumes: done is only meaningful together with busy.
module bgc_fence (
    input  logic busy,
    input  logic done,
    output logic clear
);
    // Open the fence when idle or finishing.
    always_comb begin
        clear = ~busy | done;
    end
endmodule

// File: rtl/bgc_grant_core.sv
// Module: bgc_grant_core
// Decides when the grant starts and ends, and registers the grant, halt, hung
// and driver-enable outputs. The grant starts when the recognised request
// meets open fences (or at once during processor reset). It ends when the
// early synchronizer stage shows the request gone.
// Assumes: req_early leads req_sync by exactly one cycle.
module bgc_grant_core
    import bgc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_sync,
    input  logic     req_early,
    input  logic     fences_clear,
    input  logic     chip_reset,
    input  logic     go_mode,
    input  logic     next_ext,
    output bgc_out_t out_q
);
    logic grant_nx;
    logic halt_nx;
    logic hung_nx;
    logic start_ok;

    // A grant may start in reset as soon as the request shows up, otherwise at a fence gap.
    always_comb begin
        start_ok = chip_reset | (req_sync & fences_clear);
    end

    // Next-state for the grant, halt and hung flags.
    always_comb begin
        grant_nx = req_early & (out_q.grant | start_ok);
        halt_nx  = grant_nx & (~go_mode | next_ext | out_q.halt);
        hung_nx  = grant_nx & next_ext;
    end

    // Output register: each flag gets its own flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= BGC_OUT_IDLE;
        end else begin
            out_q.grant  <= grant_nx;
            out_q.halt   <= halt_nx;
            out_q.hung   <= hung_nx;
            out_q.drv_en <= ~grant_nx;
        end
    end
endmodule

// File: rtl/bgc_checks.sv
// Module: bgc_checks
// Property checker for bus_grant_ctrl. It is bound to the top module and sees
// the ports plus the two synchronizer taps.
module bgc_checks (
    input logic clk,
    input logic rst_n,
    input logic chip_reset,
    input logic ext_busy,
    input logic ext_done,
    input logic boot_busy,
    input logic boot_done,
    input logic go_mode,
    input logic req_sync,
    input logic req_early,
    input logic bus_grant_n,
    input logic drv_en,
    input logic core_halt,
    input logic grant_hung
);
    // R3: an unfinished external access keeps the bus with the core.
    p_ext_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_busy && !ext_done && !chip_reset && bus_grant_n) |=> bus_grant_n);

    // R9: an unfinished boot byte keeps the bus with the core.
    p_boot_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_busy && !boot_done && !chip_reset && bus_grant_n) |=> bus_grant_n);

    // R5: without go mode, a grant is never given to a running core.
    p_halt_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !go_mode |=> (bus_grant_n || core_halt));

    // R7: once the early tap drops, everything returns to idle.
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_early |=> (bus_grant_n && drv_en && !core_halt && !grant_hung));

    // R8: during processor reset, the grant follows recognition at once.
    p_reset_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_reset && req_early) |=> !bus_grant_n);

    // R2: a grant starts only from a recognised request or during processor reset.
    p_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_grant_n) |-> ($past(req_sync) || $past(chip_reset)));

    // R10: hung only while granted and halted.
    p_hung_halted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_hung |-> (!bus_grant_n && core_halt));

    // R11: drivers are off exactly while the bus is lent.
    p_drv_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en == bus_grant_n);
endmodule

// File: rtl/bus_grant_ctrl.sv
// Module: bus_grant_ctrl (top)
// Lends the processor bus to an external master. It synchronizes the request,
// combines the access fences and drives the grant, driver-enable, halt and
// hung outputs from one register bank.
// Assumes: status inputs are synchronous to clk.
module bus_grant_ctrl
    import bgc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req_n,
    input  logic chip_reset,
    input  logic ext_busy,
    input  logic ext_done,
    input  logic boot_busy,
    input  logic boot_done,
    input  logic next_ext,
    input  logic go_mode,
    output logic bus_grant_n,
    output logic drv_en,
    output logic core_halt,
    output logic grant_hung
);
    logic                     req_sync;
    logic                     req_early;
    logic [BGC_NUM_FENCE-1:0] busy_v;
    logic [BGC_NUM_FENCE-1:0] done_v;
    logic [BGC_NUM_FENCE-1:0] clear_v;
    logic                     fences_clear;
    bgc_out_t                 out_q;

    bgc_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_n_async (bus_req_n),
        .req_sync    (req_sync),
        .req_early   (req_early)
    );

    // Gather fence sources into vectors.
    always_comb begin
        busy_v[BGC_FENCE_EXT]  = ext_busy;
        done_v[BGC_FENCE_EXT]  = ext_done;
        busy_v[BGC_FENCE_BOOT] = boot_busy;
        done_v[BGC_FENCE_BOOT] = boot_done;
    end

    genvar gf;
    generate
        for (gf = 0; gf < BGC_NUM_FENCE; gf++) begin : g_fence
            bgc_fence u_fence (
                .busy  (busy_v[gf]),
                .done  (done_v[gf]),
                .clear (clear_v[gf])
            );
        end
    endgenerate

    // All fences must be open for a normal grant start.
    always_comb begin
        fences_clear = &clear_v;
    end

    bgc_grant_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_sync     (req_sync),
        .req_early    (req_early),
        .fences_clear (fences_clear),
        .chip_reset   (chip_reset),
        .go_mode      (go_mode),
        .next_ext     (next_ext),
        .out_q        (out_q)
    );

    // Map the register bank to the pin polarities.
    always_comb begin
        bus_grant_n = ~out_q.grant;
        drv_en      = out_q.drv_en;
        core_halt   = out_q.halt;
        grant_hung  = out_q.hung;
    end
endmodule

bind bus_grant_ctrl bgc_checks u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .chip_reset  (chip_reset),
    .ext_busy    (ext_busy),
    .ext_done    (ext_done),
    .boot_busy   (boot_busy),
    .boot_done   (boot_done),
    .go_mode     (go_mode),
    .req_sync    (req_sync),
    .req_early   (req_early),
    .bus_grant_n (bus_grant_n),
    .drv_en      (drv_en),
    .core_halt   (core_halt),
    .grant_hung  (grant_hung)
);

// File: tb/tb_bus_grant_ctrl.sv
// Bench for bus_grant_ctrl: directed corner cases, then seeded random stimulus.
// A cycle model built from the requirements predicts every output.
module tb_bus_grant_ctrl;
    logic clk = 1'b0;
    logic rst_n, bus_req_n, chip_reset, ext_busy, ext_done;
    logic boot_busy, boot_done, next_ext, go_mode;
    logic bus_grant_n, drv_en, core_halt, grant_hung;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    bus_grant_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_req_n(bus_req_n), .chip_reset(chip_reset),
        .ext_busy(ext_busy), .ext_done(ext_done), .boot_busy(boot_busy),
        .boot_done(boot_done), .next_ext(next_ext), .go_mode(go_mode),
        .bus_grant_n(bus_grant_n), .drv_en(drv_en), .core_halt(core_halt),
        .grant_hung(grant_hung)
    );

    // Cycle model of the requirements.
    logic m_s1, m_s2, m_g, m_h, m_hung;

    function automatic logic f_grant(logic s1, logic s2, logic g, logic rc,
                                     logic eb, logic ed, logic bb, logic bd);
        return s1 & (g | rc | (s2 & (~eb | ed) & (~bb | bd)));
    endfunction

    always @(posedge clk) begin
        logic g_n;
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_g <= 0; m_h <= 0; m_hung <= 0;
        end else begin
            g_n = f_grant(m_s1, m_s2, m_g, chip_reset, ext_busy, ext_done, boot_busy, boot_done);
            m_g    <= g_n;
            m_h    <= g_n & (~go_mode | next_ext | m_h);
            m_hung <= g_n & next_ext;
            m_s2   <= m_s1;
            m_s1   <= ~bus_req_n;
        end
    end

    task automatic chk(logic act, logic exp, string req, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cmp_model();
        chk(bus_grant_n, ~m_g, "R2", "bus_grant_n vs model");
        chk(drv_en, ~m_g, "R11", "drv_en vs model");
        chk(core_halt, m_h, "R5", "core_halt vs model");
        chk(grant_hung, m_hung, "R10", "grant_hung vs model");
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            cmp_model();
        end
    endtask

    task automatic release_bus();
        bus_req_n = 1'b1;
        tick(1);
        chk(bus_grant_n, 1'b0, "R7", "grant held one edge after release");
        tick(1);
        chk(bus_grant_n, 1'b1, "R7", "grant dropped");
        chk(drv_en, 1'b1, "R7", "drivers back on");
        chk(core_halt, 1'b0, "R7", "halt dropped");
        chk(grant_hung, 1'b0, "R7", "hung dropped");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; bus_req_n = 1; chip_reset = 0; ext_busy = 0; ext_done = 0;
        boot_busy = 0; boot_done = 0; next_ext = 0; go_mode = 0;
        @(negedge clk);
        tick(3);
        // R1: reset state
        chk(bus_grant_n, 1'b1, "R1", "grant in reset");
        chk(drv_en, 1'b1, "R1", "drv_en in reset");
        chk(core_halt, 1'b0, "R1", "halt in reset");
        chk(grant_hung, 1'b0, "R1", "hung in reset");
        rst_n = 1;
        tick(2);
        chk(bus_grant_n, 1'b1, "R1", "idle after reset");

        // R2 idle grant, R5 halt with grant, R11 drivers off
        bus_req_n = 0;
        tick(2);
        chk(bus_grant_n, 1'b1, "R2", "not yet granted at recognition");
        tick(1);
        chk(bus_grant_n, 1'b0, "R2", "granted cycle after recognition");
        chk(drv_en, 1'b0, "R11", "drivers off with grant");
        chk(core_halt, 1'b1, "R5", "halt with grant, go off");
        tick(3);
        chk(core_halt, 1'b1, "R5", "halt held");
        release_bus();

        // R3 busy access, then R4 second access pending
        ext_busy = 1;
        bus_req_n = 0;
        tick(6);
        chk(bus_grant_n, 1'b1, "R3", "no grant during access");
        ext_done = 1; next_ext = 1;
        tick(1);
        ext_busy = 0; ext_done = 0;
        chk(bus_grant_n, 1'b0, "R3", "grant after access done");
        chk(grant_hung, 1'b1, "R4", "second access hung");
        tick(4);
        chk(bus_grant_n, 1'b0, "R4", "grant kept between accesses");
        chk(grant_hung, 1'b1, "R10", "hung held");
        release_bus();
        next_ext = 0;
        tick(1);

        // R6 go mode
        go_mode = 1;
        bus_req_n = 0;
        tick(3);
        chk(bus_grant_n, 1'b0, "R6", "granted in go mode");
        chk(core_halt, 1'b0, "R6", "core running in go mode");
        next_ext = 1;
        tick(1);
        chk(core_halt, 1'b1, "R6", "halt on external need");
        chk(grant_hung, 1'b1, "R10", "hung on external need");
        next_ext = 0;
        tick(1);
        chk(core_halt, 1'b1, "R6", "halt sticky");
        chk(grant_hung, 1'b0, "R10", "hung cleared");
        release_bus();
        go_mode = 0;

        // R8 processor reset
        chip_reset = 1; ext_busy = 1;
        bus_req_n = 0;
        tick(1);
        chk(bus_grant_n, 1'b1, "R8", "before recognition");
        tick(1);
        chk(bus_grant_n, 1'b0, "R8", "grant at recognition in reset");
        release_bus();
        chip_reset = 0; ext_busy = 0;

        // R9 boot byte
        boot_busy = 1;
        bus_req_n = 0;
        tick(5);
        chk(bus_grant_n, 1'b1, "R9", "no grant during byte load");
        boot_done = 1;
        tick(1);
        boot_busy = 0; boot_done = 0;
        chk(bus_grant_n, 1'b0, "R9", "grant after byte");
        release_bus();

        // Random phase against the model.
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4000; c++) begin
            if (($urandom % 12) == 0) bus_req_n = ~bus_req_n;
            ext_busy   = ($urandom % 3) == 0;
            ext_done   = ext_busy && (($urandom % 4) == 0);
            boot_busy  = ($urandom % 5) == 0;
            boot_done  = boot_busy && (($urandom % 3) == 0);
            next_ext   = ($urandom % 3) == 0;
            chip_reset = ($urandom % 40) == 0;
            if (($urandom % 50) == 0) go_mode = ~go_mode;
            tick(1);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule